// File: doc/BRIEF.md
# Link power-mode sequencer

This controller decides when the pieces of a serial link transmitter may draw power. It has four modes: shutdown, standby, acquire and transmit. It moves between them on three inputs. The first is an asynchronous enable pin. The second is a flag from a clock-activity monitor saying that the pixel clock is running. The third is a lock flag from the PLL. All of its timing comes from a slow free-running reference clock. The filter window on the enable pin and the lock deadline are both counted in cycles of that clock.

The enable pin is first synchronised and then deglitched. A new level takes effect only after it has held for the whole filter window. The one exception is the first cycle after reset: there the synchronised pin level is used at once, with no filter delay. The outputs switch on the PLL, the serializer, the clock-lane driver, the data-lane driver and the activity monitor. The lane drivers stay off through acquire. On entry to transmit the block turns things on in three steps: first the serializer loads a frame, then the clock lane starts, then the data lane starts. If the PLL does not report lock within the deadline, the block drops back to standby and sets a sticky flag.

Top module: `link_pwr_seq`

## Requirements
- R1: In the first reference cycle after reset is released, the mode becomes standby if the synchronised enable pin is high, and shutdown if it is low, with no filter delay. The lock-timeout flag is 0 after reset.
- R2: After power-up, a new enable level takes effect only once it has held for FILT_CYC consecutive reference cycles after the two-flop synchroniser. FILT_CYC is REF_HZ/1000 × FILT_US / 1000. A pulse of either polarity shorter than that leaves the mode unchanged.
- R3: The `mode` port encodes shutdown as 0, standby as 1, acquire as 2 and transmit as 3. In shutdown, `pll_en`, `mon_en`, `ser_en`, `clk_oe` and `dat_oe` are all 0.
- R4: In standby, only `mon_en` is 1.
- R5: In standby, a high `clk_active` moves the block to acquire on the next cycle. In acquire, `pll_en` and `mon_en` are 1, and `ser_en`, `clk_oe` and `dat_oe` are 0.
- R6: In acquire, a high `pll_locked` moves the block to transmit. In the first transmit cycle only `ser_en` is added. `clk_oe` rises one cycle later, and `dat_oe` rises one cycle after that. All three then stay high while in transmit.
- R7: A low `clk_active` in acquire or transmit returns the block to standby on the next cycle, which drops `pll_en`.
- R8: A filtered low enable takes the block to shutdown from any other mode.
- R9: If acquire lasts LOCK_CYC cycles without lock, the block returns to standby and sets `lock_timeout`. LOCK_CYC is REF_HZ/1000 × LOCK_US / 1000. The flag then stays high until reset.
- R10: When several conditions apply in one cycle, they take priority in this order: filtered enable low, then clock loss, then lock, then timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| en_pin | input | 1 | Asynchronous transmitter enable pin |
| clk_active | input | 1 | Pixel clock present, from the activity monitor |
| pll_locked | input | 1 | PLL lock report |
| mode | output | 2 | Current mode (0 shutdown, 1 standby, 2 acquire, 3 transmit) |
| pll_en | output | 1 | PLL enable |
| mon_en | output | 1 | Clock-activity monitor enable |
| ser_en | output | 1 | Serializer enable (loads the first frame) |
| clk_oe | output | 1 | Clock-lane driver enable |
| dat_oe | output | 1 | Data-lane driver enable |
| lock_timeout | output | 1 | Sticky flag: lock deadline missed |

## Verification
The bench builds the block with REF_HZ = 1 MHz, FILT_US = 10 and LOCK_US = 200. This gives a filter window of 10 cycles and a lock window of 200 cycles. Both boundaries are therefore short enough to test exactly: a 9-cycle pulse must be rejected, and the deadline is checked one cycle before and at the moment it expires. With these short windows, every mode path fits in a run of about a thousand cycles. That includes both power-up levels, the step-by-step turn-on in transmit, and the cases where several conditions arrive in the same cycle.

// File: rtl/link_pwr_seq.sv
module link_pwr_seq #(
  parameter int REF_HZ  = 1_000_000,
  parameter int FILT_US = 10,
  parameter int LOCK_US = 2000
)(
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       clk_active,
  input  logic       pll_locked,
  output logic [1:0] mode,
  output logic       pll_en,
  output logic       mon_en,
  output logic       ser_en,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic       lock_timeout
);
  localparam int KHZ      = REF_HZ / 1000;
  localparam int FILT_RAW = KHZ * FILT_US / 1000;
  localparam int LOCK_RAW = KHZ * LOCK_US / 1000;
  localparam int FILT_CYC = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int LOCK_CYC = (LOCK_RAW < 1) ? 1 : LOCK_RAW;
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int LW = $clog2(LOCK_CYC + 1);

  localparam logic [1:0] M_OFF  = 2'd0;
  localparam logic [1:0] M_IDLE = 2'd1;
  localparam logic [1:0] M_ACQ  = 2'd2;
  localparam logic [1:0] M_TX   = 2'd3;

  logic          en_m, en_s;
  logic          boot, en_q;
  logic [FW-1:0] fcnt;
  logic [LW-1:0] wcnt;
  logic [1:0]    step;
  logic [1:0]    nxt;
  logic          expire, stay_acq, stay_tx;

  always_ff @(posedge clk_ref) begin
    en_m <= en_pin;
    en_s <= en_m;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      boot <= 1'b1;
      en_q <= 1'b0;
      fcnt <= '0;
    end else if (boot) begin
      boot <= 1'b0;
      en_q <= en_s;
      fcnt <= '0;
    end else if (en_s == en_q) begin
      fcnt <= '0;
    end else if (fcnt == FW'(FILT_CYC - 1)) begin
      en_q <= en_s;
      fcnt <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end
  end

  assign expire = (wcnt == LW'(LOCK_CYC - 1));

  always_comb begin
    nxt = mode;
    if (!en_q) nxt = M_OFF;
    else begin
      case (mode)
        M_OFF:   nxt = M_IDLE;
        M_IDLE:  if (clk_active) nxt = M_ACQ;
        M_ACQ: begin
          if (!clk_active)     nxt = M_IDLE;
          else if (pll_locked) nxt = M_TX;
          else if (expire)     nxt = M_IDLE;
        end
        default: if (!clk_active) nxt = M_IDLE;
      endcase
    end
  end

  assign stay_acq = (mode == M_ACQ) && (nxt == M_ACQ);
  assign stay_tx  = (mode == M_TX)  && (nxt == M_TX);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      mode         <= M_OFF;
      wcnt         <= '0;
      step         <= 2'd0;
      lock_timeout <= 1'b0;
    end else if (boot) begin
      mode <= en_s ? M_IDLE : M_OFF;
    end else begin
      mode <= nxt;
      wcnt <= stay_acq ? wcnt + 1'b1 : '0;
      if (!stay_tx)           step <= 2'd0;
      else if (step != 2'd2)  step <= step + 1'b1;
      if (mode == M_ACQ && en_q && clk_active && !pll_locked && expire)
        lock_timeout <= 1'b1;
    end
  end

  assign pll_en = mode[1];
  assign mon_en = (mode != M_OFF);
  assign ser_en = (mode == M_TX);
  assign clk_oe = (mode == M_TX) && (step != 2'd0);
  assign dat_oe = (mode == M_TX) && (step == 2'd2);
endmodule

// File: rtl/link_pwr_seq_chk.sv
module link_pwr_seq_chk (
  input logic       clk_ref,
  input logic       rst_n,
  input logic       clk_active,
  input logic       pll_locked,
  input logic [1:0] mode,
  input logic       pll_en,
  input logic       mon_en,
  input logic       ser_en,
  input logic       clk_oe,
  input logic       dat_oe,
  input logic       lock_timeout
);
  a_r3_shutdown_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == 2'd0) |-> !(pll_en || mon_en || ser_en || clk_oe || dat_oe));

  a_r4_standby_monitor_only: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == 2'd1) |-> (mon_en && !pll_en && !ser_en && !clk_oe && !dat_oe));

  a_r5_acquire_drivers_off: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode == 2'd2) |-> (pll_en && !clk_oe && !dat_oe));

  a_r6_serializer_after_lock: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(ser_en) |-> $past(pll_locked));

  a_r6_data_after_clock: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(dat_oe) |-> $past(clk_oe));

  a_r7_clock_loss_leaves: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode[1] && !clk_active) |=> !mode[1]);

  a_r9_timeout_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lock_timeout |=> lock_timeout);
endmodule

bind link_pwr_seq link_pwr_seq_chk u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .clk_active(clk_active), .pll_locked(pll_locked),
  .mode(mode), .pll_en(pll_en), .mon_en(mon_en), .ser_en(ser_en),
  .clk_oe(clk_oe), .dat_oe(dat_oe), .lock_timeout(lock_timeout)
);

// File: tb/sim_link_pwr_seq.sv
module sim_link_pwr_seq;
  localparam int CLK_NS = 1000;
  localparam int FILT   = 10;
  localparam int LOCK   = 200;

  logic clk = 1'b0, rst_n = 1'b0, en_pin = 1'b1, clk_active = 1'b0, pll_locked = 1'b0;
  logic [1:0] mode;
  logic pll_en, mon_en, ser_en, clk_oe, dat_oe, lock_timeout;

  link_pwr_seq #(.REF_HZ(1_000_000), .FILT_US(10), .LOCK_US(200)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .en_pin(en_pin), .clk_active(clk_active),
    .pll_locked(pll_locked), .mode(mode), .pll_en(pll_en), .mon_en(mon_en),
    .ser_en(ser_en), .clk_oe(clk_oe), .dat_oe(dat_oe), .lock_timeout(lock_timeout));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, cmp_on = 0;
  string tag = "R1";

  int p1 = 0, p2 = 0, m_boot = 1, m_flt = 0, m_run = 0, m_mode = 0, m_step = 0, m_wait = 0, m_tmo = 0;

  task automatic model_reset();
    m_boot = 1; m_flt = 0; m_run = 0; m_mode = 0; m_step = 0; m_wait = 0; m_tmo = 0;
  endtask

  always @(posedge clk) begin
    int nm;
    if (!rst_n) model_reset();
    else if (m_boot == 1) begin
      m_boot = 0; m_flt = p2; m_mode = (p2 == 1) ? 1 : 0;
    end else begin
      nm = m_mode;
      if (m_flt == 0) nm = 0;
      else if (m_mode == 0) nm = 1;
      else if (m_mode == 1) nm = clk_active ? 2 : 1;
      else if (m_mode == 2) begin
        if (!clk_active) nm = 1;
        else if (pll_locked) nm = 3;
        else if (m_wait == LOCK - 1) begin nm = 1; m_tmo = 1; end
      end else nm = clk_active ? 3 : 1;
      m_wait = (m_mode == 2 && nm == 2) ? m_wait + 1 : 0;
      m_step = (m_mode == 3 && nm == 3) ? ((m_step < 2) ? m_step + 1 : 2) : 0;
      if (p2 != m_flt) begin
        m_run++;
        if (m_run == FILT) begin m_flt = p2; m_run = 0; end
      end else m_run = 0;
      m_mode = nm;
    end
    p2 = p1; p1 = int'(en_pin);
  end

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: got %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    cmp(tag, "mode", int'(mode), m_mode);
    cmp(tag, "pll_en", int'(pll_en), int'(m_mode >= 2));
    cmp(tag, "mon_en", int'(mon_en), int'(m_mode != 0));
    cmp(tag, "ser_en", int'(ser_en), int'(m_mode == 3));
    cmp(tag, "clk_oe", int'(clk_oe), int'(m_mode == 3 && m_step >= 1));
    cmp(tag, "dat_oe", int'(dat_oe), int'(m_mode == 3 && m_step == 2));
    cmp(tag, "lock_timeout", int'(lock_timeout), m_tmo);
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(bit pin);
    cmp_on = 0;
    @(negedge clk);
    en_pin = pin;
    tick(3);
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cmp_on = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cyc);
      finish_run();
    end
  end

  initial begin
    tag = "R1"; do_reset(1'b1);
    cmp("R1", "boot mode high", int'(mode), 1);
    cmp("R1", "timeout clear", int'(lock_timeout), 0);
    tag = "R4"; tick(3);
    cmp("R4", "standby monitor", int'(mon_en), 1);

    tag = "R2"; en_pin = 1'b0; tick(9); en_pin = 1'b1; tick(30);
    cmp("R2", "low glitch ignored", int'(mode), 1);

    tag = "R5"; clk_active = 1'b1; tick(1);
    cmp("R5", "acquire", int'(mode), 2);
    cmp("R5", "pll on", int'(pll_en), 1);
    cmp("R5", "clk lane off", int'(clk_oe), 0);
    tick(4);

    tag = "R6"; pll_locked = 1'b1; tick(1);
    cmp("R6", "ser first", int'(ser_en), 1);
    cmp("R6", "clk not yet", int'(clk_oe), 0);
    tick(1);
    cmp("R6", "clk second", int'(clk_oe), 1);
    cmp("R6", "dat not yet", int'(dat_oe), 0);
    tick(1);
    cmp("R6", "dat third", int'(dat_oe), 1);
    tick(5);

    tag = "R7"; clk_active = 1'b0; tick(1);
    cmp("R7", "back to standby", int'(mode), 1);
    cmp("R7", "pll off", int'(pll_en), 0);
    pll_locked = 1'b0; tick(3);

    tag = "R9"; clk_active = 1'b1; tick(1);
    cmp("R9", "acquire entered", int'(mode), 2);
    tick(LOCK - 1);
    cmp("R9", "still acquiring", int'(mode), 2);
    tick(1);
    cmp("R9", "timed out", int'(mode), 1);
    cmp("R9", "flag set", int'(lock_timeout), 1);
    clk_active = 1'b0; tick(4);

    tag = "R10"; clk_active = 1'b1; tick(1);
    clk_active = 1'b0; pll_locked = 1'b1; tick(1);
    cmp("R10", "clock loss beats lock", int'(mode), 1);
    pll_locked = 1'b0; tick(2);

    tag = "R8"; clk_active = 1'b1; tick(1); pll_locked = 1'b1; tick(4);
    en_pin = 1'b0; tick(12);
    cmp("R8", "held before filter", int'(mode), 3);
    tick(1);
    cmp("R8", "shutdown", int'(mode), 0);
    tag = "R3";
    cmp("R3", "all off", int'({pll_en, mon_en, ser_en, clk_oe, dat_oe}), 0);
    cmp("R9", "flag sticky", int'(lock_timeout), 1);
    clk_active = 1'b0; pll_locked = 1'b0; tick(3);

    tag = "R2"; en_pin = 1'b1; tick(9); en_pin = 1'b0; tick(30);
    cmp("R2", "high glitch ignored", int'(mode), 0);
    en_pin = 1'b1; tick(12);
    cmp("R2", "not yet enabled", int'(mode), 0);
    tick(1);
    cmp("R2", "enabled after window", int'(mode), 1);
    tick(5);

    tag = "R1"; do_reset(1'b0);
    cmp("R1", "boot mode low", int'(mode), 0);
    cmp("R1", "timeout cleared", int'(lock_timeout), 0);
    tick(5);
    finish_run();
  end
endmodule